// File: doc/BRIEF.md
# ADC Serial Result Output Port

This block is the readout side of a 16-bit converter. Each time the conversion engine finishes, it presents a result word together with a one-cycle load strobe. The block latches the word, applies the selected output coding, and sends it out on a single serial data pin with the most significant bit first. The conversion engine and any parallel readout path are outside this block.

There are two clocking modes. In master mode the block makes its own serial clock from the system clock and drives a frame-sync strobe while the data is valid. In slave mode a host supplies the serial clock, which is gated by the chip-select and read inputs. The host also picks which edge of that clock advances the data. A slave read that is still in progress when the next result arrives is abandoned, and the block pulses an error output. The external clock is sampled through a synchronizer in the system clock domain. All other logic is synchronous to that clock.

Top module: `adc_serial_readout`

## Requirements
- R1: After reset, `sdout_o`, `sclk_o` and `rd_err_o` are 0, and `sync_o` equals `sync_invert_i`.
- R2: A word is sent most significant bit first. Bit 15 is sent on the first serial clock and bit 0 on the sixteenth.
- R3: The coding is taken from `fmt_twos_i` when `result_load_i` is high. At 0 the word is sent unchanged. At 1, bit 15 of the word is inverted before it is sent, which gives two's complement.
- R4: The port is enabled only while both `cs_n_i` and `rd_n_i` are 0. While it is disabled, `sdout_o` is 0, `sclk_o` is 0, edges on `sclk_ext_i` are ignored and the bit position is cleared. The next enabled read therefore starts again at bit 15.
- R5: Slave mode is selected with `master_mode_i`=0. With `clk_invert_i`=0, a rising edge of `sclk_ext_i` presents the next bit. With `clk_invert_i`=1, a falling edge does. The new bit is on `sdout_o` no more than three system clock cycles after the edge.
- R6: In master mode, one enabled read gives exactly 16 rising edges on `sclk_o`. After that, `sclk_o` and `sdout_o` stay at 0 until the port is disabled.
- R7: In master mode, `sdout_o` does not change in the system clock cycle in which `sclk_o` rises or falls.
- R8: In master mode, the frame sync is active from the first bit until the end of the last bit's clock period. Frame active drives `sync_o` high when `sync_invert_i`=0 and low when `sync_invert_i`=1. In slave mode, `sync_o` stays at the inactive level.
- R9: In slave mode, a load that arrives after 1 to 15 bits of an enabled read have been sent sets `rd_err_o` high for exactly one cycle, the cycle after the load. The new word replaces the old one, and the read restarts at bit 15.
- R10: No error is flagged for a load that arrives when no bit has been sent yet, when all 16 bits have been sent, or when the block is in master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| result_i | input | 16 | Conversion result word |
| result_load_i | input | 1 | One-cycle strobe that latches `result_i` |
| fmt_twos_i | input | 1 | 1 selects two's-complement coding |
| master_mode_i | input | 1 | 1 makes the serial clock internally, 0 takes it from `sclk_ext_i` |
| clk_invert_i | input | 1 | Slave active edge: 0 rising, 1 falling |
| sync_invert_i | input | 1 | Frame-sync polarity: 0 active high, 1 active low |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read enable, active low |
| sclk_ext_i | input | 1 | External serial clock for slave mode |
| sdout_o | output | 1 | Serial data out |
| sclk_o | output | 1 | Generated serial clock in master mode |
| sync_o | output | 1 | Frame sync |
| rd_err_o | output | 1 | Incomplete-read error pulse |

## Verification
The assertions take for granted that `result_load_i` is a single-cycle strobe. They also assume that the mode and polarity inputs change only while the port is disabled, and that the port is enabled only while `sclk_ext_i` sits at its idle level. The idle level is low when rising edges are active and high when falling edges are active. The stimulus follows all of these assumptions. It moves the external clock only in phases of five or more system cycles. It changes the mode and polarity selects between reads, and it drives loads for exactly one cycle at a falling edge of the system clock.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

  typedef enum logic [1:0] {
    MC_IDLE = 2'd0,
    MC_RUN  = 2'd1,
    MC_DONE = 2'd2
  } mclk_state_e;

  localparam logic [1:0] QTR_LOW_A  = 2'd0;
  localparam logic [1:0] QTR_HIGH_A = 2'd1;
  localparam logic [1:0] QTR_HIGH_B = 2'd2;
  localparam logic [1:0] QTR_LOW_B  = 2'd3;

endpackage

// File: rtl/ser_edge_detect.sv
module ser_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic en_i,
  input  logic invert_i,
  output logic active_o
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic gated, prev_q, prev_d;
  logic rise, fall;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], sclk_i};
    gated  = sync_q[SYNC_STAGES-1] & en_i;
    prev_d = gated;
    rise   = gated & ~prev_q;
    fall   = ~gated & prev_q;
    active_o = invert_i ? fall : rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

endmodule

// File: rtl/ser_master_clkgen.sv
module ser_master_clkgen
  import adc_ser_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int QUARTER_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic restart_i,
  output logic adv_o,
  output logic sclk_o,
  output logic frame_o
);

  localparam int QW = (QUARTER_CYC > 1) ? $clog2(QUARTER_CYC) : 1;
  localparam int BW = $clog2(DATA_W);
  localparam int RW = $clog2(DATA_W + 2);
  localparam logic [QW-1:0] Q_LAST = QW'(QUARTER_CYC - 1);
  localparam logic [BW-1:0] B_LAST = BW'(DATA_W - 1);

  mclk_state_e   state_q, state_d;
  logic [QW-1:0] qcnt_q, qcnt_d;
  logic [1:0]    quarter_q, quarter_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          adv;

  always_comb begin
    state_d   = state_q;
    qcnt_d    = qcnt_q;
    quarter_d = quarter_q;
    bit_d     = bit_q;
    adv       = 1'b0;
    if (!en_i || restart_i) begin
      state_d = MC_IDLE;
    end else begin
      case (state_q)
        MC_IDLE: begin
          state_d   = MC_RUN;
          adv       = 1'b1;
          qcnt_d    = '0;
          quarter_d = QTR_LOW_A;
          bit_d     = '0;
        end
        MC_RUN: begin
          if (qcnt_q == Q_LAST) begin
            qcnt_d    = '0;
            quarter_d = quarter_q + 2'd1;
            if (quarter_q == QTR_LOW_B) begin
              if (bit_q == B_LAST) begin
                state_d = MC_DONE;
              end else begin
                bit_d = bit_q + BW'(1);
                adv   = 1'b1;
              end
            end
          end else begin
            qcnt_d = qcnt_q + QW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= MC_IDLE;
      qcnt_q    <= '0;
      quarter_q <= QTR_LOW_A;
      bit_q     <= '0;
    end else begin
      state_q   <= state_d;
      qcnt_q    <= qcnt_d;
      quarter_q <= quarter_d;
      bit_q     <= bit_d;
    end
  end

  assign adv_o   = adv;
  assign frame_o = (state_q == MC_RUN);
  assign sclk_o  = (state_q == MC_RUN) &&
                   ((quarter_q == QTR_HIGH_A) || (quarter_q == QTR_HIGH_B));

  // checker: count generated rising edges within one read
  logic [RW-1:0] rises_q;
  logic          sclk_prev_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rises_q     <= '0;
      sclk_prev_q <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_o;
      if (!en_i || restart_i) rises_q <= '0;
      else if (sclk_o && !sclk_prev_q) rises_q <= rises_q + RW'(1);
    end
  end

  p_rise_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rises_q <= RW'(DATA_W));

  p_adv_clk_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    adv_o |-> !sclk_o);

endmodule

// File: rtl/ser_shift_core.sv
module ser_shift_core #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              fmt_twos_i,
  input  logic              en_i,
  input  logic              adv_i,
  input  logic              master_i,
  input  logic              frame_i,
  output logic              sdo_o,
  output logic              err_o
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);

  logic [DATA_W-1:0] word_q, word_d, word_sh;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              sdo_q, sdo_d;
  logic              err_q, err_d;
  logic              mid_read;

  always_comb begin
    word_d   = word_q;
    cnt_d    = cnt_q;
    sdo_d    = sdo_q;
    err_d    = 1'b0;
    word_sh  = word_q << cnt_q;
    mid_read = (cnt_q != '0) && (cnt_q != CNT_FULL);
    if (load_i) begin
      word_d = fmt_twos_i ? {~data_i[DATA_W-1], data_i[DATA_W-2:0]} : data_i;
      cnt_d  = '0;
      sdo_d  = 1'b0;
      err_d  = !master_i && en_i && mid_read;
    end else if (!en_i) begin
      cnt_d = '0;
      sdo_d = 1'b0;
    end else if (adv_i && (cnt_q != CNT_FULL)) begin
      sdo_d = word_sh[DATA_W-1];
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
      sdo_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      cnt_q  <= cnt_d;
      sdo_q  <= sdo_d;
      err_q  <= err_d;
    end
  end

  assign sdo_o = sdo_q & (~master_i | frame_i);
  assign err_o = err_q;

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + CNT_W'(1)) || (cnt_q == '0)));

  p_err_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> !err_q);

endmodule

// File: rtl/adc_serial_readout.sv
module adc_serial_readout #(
  parameter int DATA_W      = 16,
  parameter int QUARTER_CYC = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] result_i,
  input  logic              result_load_i,
  input  logic              fmt_twos_i,
  input  logic              master_mode_i,
  input  logic              clk_invert_i,
  input  logic              sync_invert_i,
  input  logic              cs_n_i,
  input  logic              rd_n_i,
  input  logic              sclk_ext_i,
  output logic              sdout_o,
  output logic              sclk_o,
  output logic              sync_o,
  output logic              rd_err_o
);

  logic rst_meta_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_q    <= rst_meta_q;
    end
  end

  logic port_en, slave_en, master_en;
  logic s_adv, m_adv, m_sclk, m_frame, adv;

  assign port_en   = ~cs_n_i & ~rd_n_i;
  assign slave_en  = port_en & ~master_mode_i;
  assign master_en = port_en & master_mode_i;

  ser_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_s_q),
    .sclk_i   (sclk_ext_i),
    .en_i     (slave_en),
    .invert_i (clk_invert_i),
    .active_o (s_adv)
  );

  ser_master_clkgen #(.DATA_W(DATA_W), .QUARTER_CYC(QUARTER_CYC)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_s_q),
    .en_i      (master_en),
    .restart_i (result_load_i),
    .adv_o     (m_adv),
    .sclk_o    (m_sclk),
    .frame_o   (m_frame)
  );

  assign adv = master_mode_i ? m_adv : s_adv;

  ser_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_s_q),
    .load_i     (result_load_i),
    .data_i     (result_i),
    .fmt_twos_i (fmt_twos_i),
    .en_i       (port_en),
    .adv_i      (adv),
    .master_i   (master_mode_i),
    .frame_i    (m_frame),
    .sdo_o      (sdout_o),
    .err_o      (rd_err_o)
  );

  assign sclk_o = master_mode_i & m_sclk;
  assign sync_o = (master_mode_i & m_frame) ^ sync_invert_i;

  p_data_stable_edges_r7: assert property (@(posedge clk) disable iff (!rst_s_q)
    (master_mode_i && $past(master_mode_i) && $past(port_en) && !$past(result_load_i)
     && (sclk_o != $past(sclk_o))) |-> $stable(sdout_o));

  p_no_sclk_when_off_r4: assert property (@(posedge clk) disable iff (!rst_s_q)
    !$past(port_en) |-> !sclk_o);

  p_err_follows_load_r9: assert property (@(posedge clk) disable iff (!rst_s_q)
    rd_err_o |-> $past(result_load_i));

endmodule

// File: tb/adc_serial_readout_tb.sv
module adc_serial_readout_tb;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [15:0] result;
  logic load, fmt, master, cinv, sinv, cs_n, rd_n, sclk_ext;
  logic sdout, sclk, sync, err;

  int checks = 0;
  int fails  = 0;
  int rises  = 0;
  bit mon_req = 1'b0;
  bit mon_off = 1'b0;
  bit exp_q[$];
  string cur_tag = "R2";
  logic prev_sclk = 1'b0;
  logic rise_val  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_readout #(.DATA_W(16), .QUARTER_CYC(QTR), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .result_i(result), .result_load_i(load),
    .fmt_twos_i(fmt), .master_mode_i(master), .clk_invert_i(cinv),
    .sync_invert_i(sinv), .cs_n_i(cs_n), .rd_n_i(rd_n), .sclk_ext_i(sclk_ext),
    .sdout_o(sdout), .sclk_o(sclk), .sync_o(sync), .rd_err_o(err)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit pop_exp();
    bit v;
    if (exp_q.size() == 0) return 1'bx;
    v = exp_q.pop_front();
    return v;
  endfunction

  // monitor: compares serial bits against the scoreboard queue
  always @(negedge clk) begin
    if (mon_req) begin
      if (exp_q.size() == 0) chk({cur_tag, " empty queue"}, 1, 0);
      else chk(cur_tag, int'(sdout), int'(pop_exp()));
    end
    if (master && !mon_off) begin
      if (sclk && !prev_sclk) begin
        rises++;
        rise_val = sdout;
        if (exp_q.size() == 0) chk({cur_tag, " empty queue"}, 1, 0);
        else chk(cur_tag, int'(sdout), int'(pop_exp()));
      end
      if (!sclk && prev_sclk) chk("R7 stable at fall", int'(sdout), int'(rise_val));
    end
    prev_sclk = sclk;
  end

  task automatic push_word(logic [15:0] w);
    for (int i = 15; i >= 0; i--) exp_q.push_back(w[i]);
  endtask

  task automatic load_word(logic [15:0] w, logic f);
    @(negedge clk);
    result = w; fmt = f; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic port(bit on);
    @(negedge clk);
    cs_n = !on; rd_n = !on;
  endtask

  task automatic slave_bits(logic [15:0] w, int first, int n, logic inv);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sclk_ext = !inv;
      repeat (5) @(negedge clk);
      exp_q.push_back(w[15-(first+i)]);
      @(posedge clk); mon_req = 1'b1;
      @(posedge clk); mon_req = 1'b0;
      @(negedge clk); sclk_ext = inv;
      repeat (5) @(negedge clk);
    end
  endtask

  task automatic master_read(logic [15:0] w, logic f, logic si, string tag);
    master = 1'b1; sinv = si;
    load_word(w, f);
    exp_q.delete();
    push_word(f ? (w ^ 16'h8000) : w);
    cur_tag = tag;
    rises = 0;
    port(1);
    repeat (3) @(negedge clk);
    chk("R8 sync active", int'(sync), int'(!si));
    repeat (64*QTR + 10) @(negedge clk);
    chk("R6 sixteen clocks", rises, 16);
    chk("R6 clock idle after", int'(sclk), 0);
    chk("R6 data idle after", int'(sdout), 0);
    chk("R8 sync inactive after", int'(sync), int'(si));
    chk("R2 queue drained", exp_q.size(), 0);
    port(0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; result = '0; load = 1'b0; fmt = 1'b0; master = 1'b0;
    cinv = 1'b0; sinv = 1'b0; cs_n = 1'b1; rd_n = 1'b1; sclk_ext = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 sdout", int'(sdout), 0);
    chk("R1 sclk", int'(sclk), 0);
    chk("R1 sync", int'(sync), 0);
    chk("R1 err", int'(err), 0);
    sinv = 1'b1;
    @(negedge clk);
    chk("R8 slave sync inactive", int'(sync), 1);
    sinv = 1'b0;

    // R2, R6, R8: master binary, active-high sync
    master_read(16'hA5C3, 1'b0, 1'b0, "R2 master bit");
    // R3, R8: master two's complement, active-low sync
    master_read(16'h8001, 1'b1, 1'b1, "R3 master twos bit");
    sinv = 1'b0;

    // R10: load in mid master read flags nothing
    mon_off = 1'b1;
    master = 1'b1;
    load_word(16'h00FF, 1'b0);
    port(1);
    repeat (40) @(negedge clk);
    load_word(16'h1111, 1'b0);
    chk("R10 master no err", int'(err), 0);
    @(negedge clk);
    chk("R10 master no err later", int'(err), 0);
    port(0);
    repeat (3) @(negedge clk);
    exp_q.delete();
    mon_off = 1'b0;
    master = 1'b0;

    // R5: slave, rising edge
    cinv = 1'b0; sclk_ext = 1'b0;
    load_word(16'h1234, 1'b0);
    port(1);
    cur_tag = "R5 slave rising";
    slave_bits(16'h1234, 0, 16, 1'b0);
    chk("R8 slave sync idle", int'(sync), 0);
    port(0);

    // R5, R3: slave, falling edge, two's complement
    cinv = 1'b1; sclk_ext = 1'b1;
    load_word(16'hC3A5, 1'b1);
    port(1);
    cur_tag = "R5 slave falling";
    slave_bits(16'h43A5, 0, 16, 1'b1);
    port(0);
    cinv = 1'b0;
    @(negedge clk); sclk_ext = 1'b0;

    // R4: disabled port ignores clock, read restarts at MSB
    load_word(16'h9ABC, 1'b0);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); sclk_ext = 1'b1;
      repeat (5) @(negedge clk);
      chk("R4 rd high data idle", int'(sdout), 0);
      @(negedge clk); sclk_ext = 1'b0;
      repeat (5) @(negedge clk);
    end
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
    @(negedge clk); sclk_ext = 1'b1;
    repeat (5) @(negedge clk);
    chk("R4 cs high data idle", int'(sdout), 0);
    @(negedge clk); sclk_ext = 1'b0;
    repeat (5) @(negedge clk);
    port(1);
    cur_tag = "R4 restart at MSB";
    slave_bits(16'h9ABC, 0, 4, 1'b0);
    port(0);
    port(1);
    cur_tag = "R4 restart after disable";
    slave_bits(16'h9ABC, 0, 2, 1'b0);
    port(0);

    // R9: overrun of an incomplete slave read
    load_word(16'h1234, 1'b0);
    port(1);
    cur_tag = "R9 before overrun";
    slave_bits(16'h1234, 0, 5, 1'b0);
    load_word(16'hBEEF, 1'b0);
    chk("R9 err pulse", int'(err), 1);
    @(negedge clk);
    chk("R9 err one cycle", int'(err), 0);
    cur_tag = "R9 new word from MSB";
    slave_bits(16'hBEEF, 0, 16, 1'b0);

    // R10: load after a complete read, and before any bit
    load_word(16'h5555, 1'b0);
    chk("R10 complete no err", int'(err), 0);
    load_word(16'h6666, 1'b0);
    chk("R10 not started no err", int'(err), 0);
    port(0);

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule